// File: doc/BRIEF.md
# Serial Page-Write Controller

This block is the device-side front end of a three-wire serial memory that stores 16-bit words. It watches chip select, serial clock, serial data in and a write-enable pin, all sampled by the system clock `clk`. It recognises a page-write command, captures one to four data words into a staging buffer, and then runs a timed programming cycle. At the end of that cycle the words are written into an internal word array, one per clock, through a write-strobe port.

A frame is sent most significant bit first, in this order: a start bit of 1, a 2-bit opcode, the first word address, then the data words. Only the two lowest address bits step from one word to the next, so a frame never leaves its four-word page. A frame is dropped as a whole in any of these cases:
- any word falls in the protected region;
- write enable is seen low;
- chip select falls at any moment other than the gap that follows a complete word.

While programming runs, the serial output reads low (busy). At all other times it reads high (ready).

States:
- `ST_IDLE`: hunts for the start bit.
- `ST_OPCODE`, `ST_ADDRESS`, `ST_DATA`: shift their fields.
- `ST_WORD_END`: the gap after a complete word.
- `ST_DRAIN`: waits for chip select to drop after a rejected frame.
- `ST_PROGRAM`: the timed busy period.
- `ST_COMMIT`: writes the staged words into the array.

Transitions:
- Idle to opcode on a start bit.
- Opcode to address on the page-write opcode, or to drain on any other.
- Address to data after the last address bit.
- Data to word-end after bit 16.
- Word-end back to data when a further serial clock edge arrives, or to drain if four words are already held.
- Word-end to program when chip select falls and no word is protected, or to idle when one is.
- Any shifting state to idle on an early chip-select fall, or to drain when write enable is low.
- Program to commit when the timer expires.
- Commit to idle after the last staged word.

Top module: `mw_page_writer`

## Requirements
- R1: A frame begins at the first rising serial clock edge that samples data 1 while chip select is high. Rising edges that sample 0 before it are ignored.
- R2: The two bits after the start bit form the opcode, MSB first. Only the value `PAGE_OPC` (default 2'b01) continues the frame. Any other opcode causes the rest of the frame to be ignored until chip select goes low.
- R3: After the opcode come `ADDR_W` address bits and then 16-bit words, each MSB first. Word k of a frame (k = 0..3) is written to the address whose upper bits equal the frame address and whose two low bits equal (frame address + k) mod 4.
- R4: If any word of a frame would land at an address greater than or equal to `prot_floor` (an `ADDR_W+1`-bit value), nothing is written and no busy period follows.
- R5: If write enable is low at any rising serial clock edge sampled during a frame, the frame is ignored.
- R6: Programming starts only when chip select falls after a complete word and before the next rising serial clock edge. A fall inside a word, a fall after extra bits, or a fifth word discards the frame.
- R7: After an accepted frame of n words, the serial output reads 0 for exactly `PROG_CYCLES` + n clock cycles. It reads 1 at all other times.
- R8: Array writes occur only after the programming time has elapsed. They happen one word per clock, in word order, with exactly n write strobes per accepted frame.
- R9: A frame sent while the serial output reads busy has no effect.
- R10: After reset the serial output reads 1 and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock; its rising edges sample `ser_din` |
| ser_din | input | 1 | Serial data in |
| wr_en_pin | input | 1 | Write enable; must stay high through the frame |
| prot_floor | input | ADDR_W+1 | Lowest protected address; 2^ADDR_W protects nothing |
| ser_dout | output | 1 | Status: 0 busy, 1 ready |
| arr_we | output | 1 | Word-array write strobe |
| arr_addr | output | ADDR_W | Word-array write address |
| arr_wdata | output | WORD_W | Word-array write data |

## Verification
The bench builds the block with a 4-bit address, the default four-word page and 16-bit words, and 100 programming cycles. The 16-word array is small enough to compare in full after every frame. Every start address is swept with every word count, under a floor that protects nothing, one that cuts through a page, and one that protects everything, so every wrap position and every partial-protection case is reached. The 100-cycle busy period is long enough to fit a complete second frame inside it.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDRESS,
        ST_DATA,
        ST_WORD_END,
        ST_DRAIN,
        ST_PROGRAM,
        ST_COMMIT
    } mw_state_e;

endpackage

// File: rtl/mw_sclk_edge.sv
module mw_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/mw_stage_buf.sv
module mw_stage_buf #(
    parameter int ADDR_W     = 8,
    parameter int WORD_W     = 16,
    parameter int PAGE_WORDS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  push,
    input  logic [WORD_W-1:0]     push_data,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [ADDR_W:0]       prot_floor,
    input  logic [$clog2(PAGE_WORDS)-1:0] rd_idx,
    output logic [WORD_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic [$clog2(PAGE_WORDS+1)-1:0] count,
    output logic                  prot_hit
);
    localparam int PW = $clog2(PAGE_WORDS);
    localparam int CW = $clog2(PAGE_WORDS + 1);

    logic [WORD_W-1:0] slots [PAGE_WORDS];
    logic [PW-1:0]     wr_idx;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [PW-1:0] k);
        return {base[ADDR_W-1:PW], base[PW-1:0] + k};
    endfunction

    assign wr_idx = count[PW-1:0];

    always_ff @(posedge clk) begin
        if (push) slots[wr_idx] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            prot_hit <= 1'b0;
        end else if (clear) begin
            count    <= '0;
            prot_hit <= 1'b0;
        end else if (push) begin
            count <= count + CW'(1);
            if ({1'b0, slot_addr(base_addr, wr_idx)} >= prot_floor) prot_hit <= 1'b1;
        end
    end

    assign rd_data = slots[rd_idx];
    assign rd_addr = slot_addr(base_addr, rd_idx);
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        remain <= '0;
        else if (load)                     remain <= TW'(CYCLES - 1);
        else if (run && remain != '0)      remain <= remain - TW'(1);
    end

    assign done = run && (remain == '0);
endmodule

// File: rtl/mw_page_writer.sv
module mw_page_writer
    import mw_pkg::*;
#(
    parameter int               ADDR_W      = 8,
    parameter int               WORD_W      = 16,
    parameter int               PAGE_WORDS  = 4,
    parameter int               PROG_CYCLES = 64,
    parameter int               OPC_W       = 2,
    parameter logic [OPC_W-1:0] PAGE_OPC    = 'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_cs,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              wr_en_pin,
    input  logic [ADDR_W:0]   prot_floor,
    output logic              ser_dout,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [WORD_W-1:0] arr_wdata
);
    localparam int PW = $clog2(PAGE_WORDS);
    localparam int CW = $clog2(PAGE_WORDS + 1);
    localparam int SW = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
    localparam int BW = $clog2(SW + 1);

    mw_state_e         st, nxt;
    logic [SW-1:0]     sh, sh_next;
    logic [BW-1:0]     bit_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [PW-1:0]     commit_idx;
    logic              rise, shifting, field_last, push, tmr_load, tmr_done, last_commit;
    logic [CW-1:0]     stg_count;
    logic              stg_prot;

    mw_sclk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (ser_clk),
        .rise (rise)
    );

    mw_stage_buf #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .PAGE_WORDS(PAGE_WORDS)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st == ST_IDLE),
        .push      (push),
        .push_data (sh_next[WORD_W-1:0]),
        .base_addr (addr_q),
        .prot_floor(prot_floor),
        .rd_idx    (commit_idx),
        .rd_data   (arr_wdata),
        .rd_addr   (arr_addr),
        .count     (stg_count),
        .prot_hit  (stg_prot)
    );

    mw_prog_timer #(
        .CYCLES(PROG_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .run  (st == ST_PROGRAM),
        .done (tmr_done)
    );

    assign sh_next     = {sh[SW-2:0], ser_din};
    assign shifting    = ser_cs && rise &&
                         (st inside {ST_OPCODE, ST_ADDRESS, ST_DATA, ST_WORD_END});
    assign field_last  = (st == ST_OPCODE  && bit_cnt == BW'(OPC_W - 1))  ||
                         (st == ST_ADDRESS && bit_cnt == BW'(ADDR_W - 1)) ||
                         (st == ST_DATA    && bit_cnt == BW'(WORD_W - 1));
    assign push        = (st == ST_DATA) && ser_cs && rise && wr_en_pin && field_last;
    assign tmr_load    = (st == ST_WORD_END) && !ser_cs && !stg_prot;
    assign last_commit = CW'(commit_idx) == (stg_count - CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (ser_cs && rise && ser_din) nxt = wr_en_pin ? ST_OPCODE : ST_DRAIN;
            end
            ST_OPCODE: begin
                if (!ser_cs)                 nxt = ST_IDLE;
                else if (rise && !wr_en_pin) nxt = ST_DRAIN;
                else if (rise && field_last)
                    nxt = (sh_next[OPC_W-1:0] == PAGE_OPC) ? ST_ADDRESS : ST_DRAIN;
            end
            ST_ADDRESS: begin
                if (!ser_cs)                 nxt = ST_IDLE;
                else if (rise && !wr_en_pin) nxt = ST_DRAIN;
                else if (rise && field_last) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (!ser_cs)                 nxt = ST_IDLE;
                else if (rise && !wr_en_pin) nxt = ST_DRAIN;
                else if (rise && field_last) nxt = ST_WORD_END;
            end
            ST_WORD_END: begin
                if (!ser_cs)                                    nxt = stg_prot ? ST_IDLE : ST_PROGRAM;
                else if (rise && !wr_en_pin)                    nxt = ST_DRAIN;
                else if (rise && stg_count == CW'(PAGE_WORDS))  nxt = ST_DRAIN;
                else if (rise)                                  nxt = ST_DATA;
            end
            ST_DRAIN:   if (!ser_cs)    nxt = ST_IDLE;
            ST_PROGRAM: if (tmr_done)   nxt = ST_COMMIT;
            ST_COMMIT:  if (last_commit) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            bit_cnt    <= '0;
            addr_q     <= '0;
            commit_idx <= '0;
        end else begin
            if (shifting) sh <= sh_next;
            if (st == ST_IDLE)                       bit_cnt <= '0;
            else if (shifting && st == ST_WORD_END)  bit_cnt <= BW'(1);
            else if (shifting && field_last)         bit_cnt <= '0;
            else if (shifting)                       bit_cnt <= bit_cnt + BW'(1);
            if (shifting && st == ST_ADDRESS && field_last) addr_q <= sh_next[ADDR_W-1:0];
            if (st == ST_PROGRAM)     commit_idx <= '0;
            else if (st == ST_COMMIT) commit_idx <= commit_idx + PW'(1);
        end
    end

    // outputs
    always_comb begin
        ser_dout = 1'b1;
        arr_we   = 1'b0;
        unique case (st)
            ST_PROGRAM: ser_dout = 1'b0;
            ST_COMMIT: begin
                ser_dout = 1'b0;
                arr_we   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mw_page_writer_chk.sv
module mw_page_writer_chk #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_WORDS  = 4,
    parameter int PROG_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_dout,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W:0]   prot_floor
);
    localparam int PW = $clog2(PAGE_WORDS);

    int unsigned low_len;
    int unsigned we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len <= 0;
            we_run  <= 0;
        end else begin
            low_len <= ser_dout ? 0 : low_len + 1;
            we_run  <= arr_we ? we_run + 1 : 0;
        end
    end

    AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !ser_dout); // R8

    AST_WE_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) |-> arr_addr[PW-1:0] == $past(arr_addr[PW-1:0]) + PW'(1)); // R3

    AST_WE_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) |-> arr_addr[ADDR_W-1:PW] == $past(arr_addr[ADDR_W-1:PW])); // R3

    AST_WE_BELOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> {1'b0, arr_addr} < prot_floor); // R4

    AST_WE_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && !$past(arr_we) |-> low_len == PROG_CYCLES); // R8

    AST_WE_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> we_run < PAGE_WORDS); // R8

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_dout |-> low_len < PROG_CYCLES + PAGE_WORDS); // R7

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arr_we) && !arr_we |-> ser_dout); // R7
endmodule

bind mw_page_writer mw_page_writer_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_WORDS (PAGE_WORDS),
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_dout  (ser_dout),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .prot_floor(prot_floor)
);

// File: tb/sim_mw_page_writer.sv
module sim_mw_page_writer;
    localparam int         CLK_PERIOD = 10;
    localparam int         AW         = 4;
    localparam int         DW         = 16;
    localparam int         PAGE       = 4;
    localparam int         PROG       = 100;
    localparam logic [1:0] OPC        = 2'b01;
    localparam int         ADDRS      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_cs = 1'b0;
    logic          ser_clk = 1'b0;
    logic          ser_din = 1'b0;
    logic          wr_en_pin = 1'b1;
    logic [AW:0]   prot_floor = 5'd16;
    logic          ser_dout;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;

    int checks = 0;
    int errors = 0;
    int seq = 0;
    int we_total;
    logic [DW-1:0] mem_seen [ADDRS];
    logic [DW-1:0] mem_exp  [ADDRS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_page_writer #(
        .ADDR_W(AW), .WORD_W(DW), .PAGE_WORDS(PAGE), .PROG_CYCLES(PROG),
        .OPC_W(2), .PAGE_OPC(OPC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_din(ser_din),
        .wr_en_pin(wr_en_pin), .prot_floor(prot_floor), .ser_dout(ser_dout),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // behavioural word array fed by the strobe port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ADDRS; a++) mem_seen[a] <= '0;
            we_total <= 0;
        end else if (arr_we) begin
            mem_seen[arr_addr] <= arr_wdata;
            we_total <= we_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b0;
        tick();
        ser_clk = 1'b1;
        tick();
    endtask

    function automatic logic [DW-1:0] word_of(input int s, input int i, input int base);
        return {8'(s), 2'(i), 2'b10, 4'(base)};
    endfunction

    function automatic int slot(input int base, input int i);
        return (base & ~3) | ((base + i) & 3);
    endfunction

    task automatic send_frame(input int base, input int n, input logic [1:0] opc, input int lead,
                              input int wen_low_at, input int cut, input int extra, input int s);
        logic [DW-1:0] w;
        ser_cs = 1'b1;
        tick();
        repeat (lead) put_bit(1'b0);
        put_bit(1'b1);
        put_bit(opc[1]);
        put_bit(opc[0]);
        for (int b = AW - 1; b >= 0; b--) put_bit(base[b]);
        for (int j = 0; j < n * DW - cut; j++) begin
            if (j == wen_low_at) wr_en_pin = 1'b0;
            w = word_of(s, j / DW, base);
            put_bit(w[DW - 1 - (j % DW)]);
        end
        repeat (extra) put_bit(1'b1);
        ser_clk = 1'b0;
        tick();
        ser_cs    = 1'b0;
        wr_en_pin = 1'b1;
    endtask

    task automatic run_case(input string req, input int base, input int n, input logic [1:0] opc,
                            input int lead, input int wl, input int cut, input int extra);
        int  lows;
        int  we0;
        int  mism;
        bit  prot;
        bit  ok;
        seq++;
        we0  = we_total;
        prot = 1'b0;
        for (int i = 0; i < n; i++) if (slot(base, i) >= int'(prot_floor)) prot = 1'b1;
        ok = !prot && opc == OPC && wl < 0 && cut == 0 && extra == 0;
        send_frame(base, n, opc, lead, wl, cut, extra, seq);
        lows = 0;
        for (int k = 0; k < PROG + 12; k++) begin
            tick();
            if (!ser_dout) lows++;
        end
        if (ok) for (int i = 0; i < n; i++) mem_exp[slot(base, i)] = word_of(seq, i, base);
        mism = 0;
        for (int a = 0; a < ADDRS; a++) if (mem_seen[a] !== mem_exp[a]) mism++;
        chk(mism == 0, req, mism, 0);
        chk(lows == (ok ? PROG + n : 0), ok ? "R7" : req, lows, ok ? PROG + n : 0);
        chk(we_total - we0 == (ok ? n : 0), ok ? "R8" : req, we_total - we0, ok ? n : 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int fl [3];
        int mism;
        int we0;
        fl[0] = 16; fl[1] = 10; fl[2] = 0;
        for (int a = 0; a < ADDRS; a++) mem_exp[a] = '0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk(ser_dout == 1'b1, "R10", int'(ser_dout), 1);
        chk(arr_we == 1'b0, "R10", int'(arr_we), 0);

        // sweep every start address, word count and three protection floors (R3, R4, R1)
        for (int f = 0; f < 3; f++) begin
            prot_floor = 5'(fl[f]);
            for (int base = 0; base < ADDRS; base++) begin
                for (int n = 1; n <= PAGE; n++) begin
                    bit p;
                    p = 1'b0;
                    for (int i = 0; i < n; i++) if (slot(base, i) >= fl[f]) p = 1'b1;
                    run_case(p ? "R4" : "R3", base, n, OPC, (base + n) % 3, -1, 0, 0);
                end
            end
        end

        prot_floor = 5'd16;
        run_case("R1", 7, 2, OPC, 5, -1, 0, 0);        // leading zeros before start bit
        run_case("R2", 3, 1, 2'b10, 0, -1, 0, 0);      // foreign opcodes ignored
        run_case("R2", 3, 1, 2'b11, 0, -1, 0, 0);
        run_case("R2", 3, 1, 2'b00, 0, -1, 0, 0);
        run_case("R5", 5, 2, OPC, 0, 0, 0, 0);         // write enable low at first data bit
        run_case("R5", 5, 2, OPC, 0, 31, 0, 0);        // write enable low at last data bit
        run_case("R5", 5, 2, OPC, 0, 20, 0, 0);
        run_case("R6", 6, 2, OPC, 0, -1, 1, 0);        // chip select falls one bit early
        run_case("R6", 6, 2, OPC, 0, -1, 9, 0);        // falls mid second word
        run_case("R6", 6, 2, OPC, 0, -1, 0, 1);        // falls after one extra bit
        run_case("R6", 8, 4, OPC, 0, -1, 0, 16);       // fifth word

        // R9: a full frame sent during the busy period must leave no trace
        seq++;
        we0 = we_total;
        send_frame(2, 1, OPC, 0, -1, 0, 0, seq);
        tick();
        tick();
        send_frame(9, 1, OPC, 0, -1, 0, 0, seq + 100);
        repeat (PROG + 12) tick();
        mem_exp[2] = word_of(seq, 0, 2);
        mism = 0;
        for (int a = 0; a < ADDRS; a++) if (mem_seen[a] !== mem_exp[a]) mism++;
        chk(mism == 0, "R9", mism, 0);
        chk(we_total - we0 == 1, "R9", we_total - we0, 1);
        chk(ser_dout == 1'b1, "R7", int'(ser_dout), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule